// File: doc/BRIEF.md
# Genetic Search Engine for Configuration Words

This block runs an evolutionary search over short configuration words. Each word is a chromosome of five genes, one gene per bit. A `start` pulse fills a population of eight words from an internal pseudo-random source. The engine then sends each word in turn to an external fitness evaluator, one request at a time. When every score of a generation is back, the engine keeps the words whose fitness is a large share of the generation's total. It breeds the next generation from those survivors with random crossover and single-bit mutation.

The search stops when a score reaches the largest value the score field can hold, or when a set number of generations has been evaluated. At that point the engine raises `done` and presents the best word seen in the run, with its score. Crossover and mutation rates are 8-bit thresholds. A fresh random byte below the threshold enables the operator.

Top module: `ga_search_engine`

## Requirements
- R1: After reset, `done` and `eval_req` are 0, and `best_chrom` and `best_score` are 0.
- R2: A search evaluates each of the 8 individuals of a generation exactly once. `eval_req` stays high, with `eval_chrom` stable, until a cycle where `eval_valid` is 1. `eval_req` is low in the cycle after that.
- R3: Only one evaluation is outstanding at a time. A new request is raised only after the previous one has been answered.
- R4: `best_score`/`best_chrom` are replaced only by a returned score strictly greater than the held score. An accepted `start` clears both to 0.
- R5: After all 8 scores of a generation are back, an individual is a survivor when 10·score > 8·(sum of the generation's 8 scores).
- R6: If fewer than two survivors exist, the parent pool is that generation's highest scorer twice. On a tie, the earliest one in evaluation order is used.
- R7: Every child is built from two parents drawn from the pool. Crossover applies when a random byte is below `xover_th`; it swaps all genes above a random cut between bits 1 and 4. Mutation applies when a random byte is below `mut_th`; it inverts one random gene. So with both thresholds 0, each child equals a pool member. In every case, each child is within one bit of a parent or a parent-pair splice.
- R8: A returned score of 255 sets `done` on the next edge, and no further request follows.
- R9: With no 255 score, `done` rises once `gen_limit` generations have been evaluated, which is 8·gen_limit evaluations. A limit of 0 acts as 1.
- R10: `done` holds until a new `start`. A `start` during a running search is ignored. The configuration inputs are sampled when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a search (accepted when idle or done) |
| gen_limit | input | 8 | number of generations to evaluate |
| xover_th | input | 8 | crossover probability threshold |
| mut_th | input | 8 | mutation probability threshold |
| eval_req | output | 1 | fitness request pending |
| eval_chrom | output | 5 | chromosome to be scored |
| eval_valid | input | 1 | score present this cycle |
| eval_score | input | 8 | fitness score |
| done | output | 1 | search finished |
| best_chrom | output | 5 | best chromosome seen in this run |
| best_score | output | 8 | score of `best_chrom` |

## Verification
The assertions assume that the evaluator raises `eval_valid` only while `eval_req` is high, and only as a one-cycle pulse per request. The bench honours this by answering each request once, after a random wait of zero to two cycles, and by dropping `eval_valid` on the next cycle. Configuration inputs are held steady for the whole of each run, so sampling them at `start` adds no uncertainty. Scores come from fixed policies: random values below 255, one dominant scorer per generation, all-equal, all-zero, and a single 255. These keep each run inside the stopping rules that the bench predicts.

// File: rtl/ga_pkg.sv
package ga_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEED,
    ST_ISSUE,
    ST_WAIT,
    ST_SELECT,
    ST_FIX,
    ST_PICK,
    ST_CROSS,
    ST_MUT,
    ST_WRITE,
    ST_DONE
  } ga_state_t;
endpackage

// File: rtl/ga_lfsr.sv
module ga_lfsr #(
  parameter int          W     = 16,
  parameter logic [15:0] TAPS  = 16'hB400,
  parameter logic [15:0] SEED  = 16'hACE1,
  parameter int          STEPS = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] rnd
);
  logic [W-1:0] state, nxt;

  always_comb begin
    nxt = state;
    for (int k = 0; k < STEPS; k++) begin
      nxt = nxt[0] ? ((nxt >> 1) ^ TAPS[W-1:0]) : (nxt >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEED[W-1:0];
    else     state <= nxt;
  end

  assign rnd = state;
endmodule

// File: rtl/ga_qualify.sv
module ga_qualify #(
  parameter int SW    = 8,
  parameter int SUM_W = 11,
  parameter int NUM   = 8,
  parameter int DEN   = 10
) (
  input  logic [SW-1:0]    score,
  input  logic [SUM_W-1:0] total,
  output logic             pass
);
  localparam int PW = SUM_W + 8;
  logic [PW-1:0] lhs, rhs;

  always_comb begin
    lhs  = PW'(score) * PW'(DEN);
    rhs  = PW'(total) * PW'(NUM);
    pass = lhs > rhs;
  end
endmodule

// File: rtl/ga_breed.sv
module ga_breed #(
  parameter int CW    = 5,
  parameter int CUT_W = 3,
  parameter int POS_W = 3
) (
  input  logic [CW-1:0]    pa,
  input  logic [CW-1:0]    pb,
  input  logic             do_x,
  input  logic [CUT_W-1:0] cut,
  input  logic             do_m0,
  input  logic [POS_W-1:0] pos0,
  input  logic             do_m1,
  input  logic [POS_W-1:0] pos1,
  output logic [CW-1:0]    c0,
  output logic [CW-1:0]    c1
);
  logic [CW-1:0] hi_mask, x0, x1, f0, f1;

  for (genvar i = 0; i < CW; i++) begin : g_bits
    assign hi_mask[i] = do_x && (CUT_W'(i) >= cut);
    assign f0[i]      = do_m0 && (POS_W'(i) == pos0);
    assign f1[i]      = do_m1 && (POS_W'(i) == pos1);
  end

  assign x0 = (pa & ~hi_mask) | (pb & hi_mask);
  assign x1 = (pb & ~hi_mask) | (pa & hi_mask);
  assign c0 = x0 ^ f0;
  assign c1 = x1 ^ f1;
endmodule

// File: rtl/ga_search_engine.sv
module ga_search_engine #(
  parameter int CW    = 5,
  parameter int SW    = 8,
  parameter int POP_N = 8,
  parameter int GEN_W = 8,
  parameter int TH_W  = 8,
  parameter int Q_NUM = 8,
  parameter int Q_DEN = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [GEN_W-1:0] gen_limit,
  input  logic [TH_W-1:0]  xover_th,
  input  logic [TH_W-1:0]  mut_th,
  output logic             eval_req,
  output logic [CW-1:0]    eval_chrom,
  input  logic             eval_valid,
  input  logic [SW-1:0]    eval_score,
  output logic             done,
  output logic [CW-1:0]    best_chrom,
  output logic [SW-1:0]    best_score
);
  import ga_pkg::*;

  localparam int IDX_W  = $clog2(POP_N);
  localparam int PAIRS  = POP_N / 2;
  localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int SUM_W  = SW + IDX_W;
  localparam int CUT_W  = $clog2(CW);
  localparam int POS_W  = $clog2(CW);
  localparam int RW     = 16;
  localparam logic [SW-1:0] MAX_S = {SW{1'b1}};

  ga_state_t         st;
  logic [RW-1:0]     rnd;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W:0]    nsel;
  logic [PAIR_W-1:0] pair;
  logic [SUM_W-1:0]  sum;
  logic [GEN_W:0]    gen_cnt;
  logic [GEN_W-1:0]  lim_q;
  logic [TH_W-1:0]   xth_q, mth_q;
  logic [CW-1:0]     pop [POP_N];
  logic [SW-1:0]     fit [POP_N];
  logic [CW-1:0]     pool [POP_N];
  logic [CW-1:0]     gb_chrom;
  logic [SW-1:0]     gb_score;
  logic [CW-1:0]     pa, pb;
  logic              dx, dm0, dm1;
  logic [CUT_W-1:0]  cut;
  logic              qual;
  logic [CW-1:0]     c0, c1;
  logic [IDX_W-1:0]  ia, ib;
  logic [CUT_W-1:0]  cut_n;
  logic [POS_W-1:0]  pos0, pos1;

  ga_lfsr #(.W(RW)) u_rng (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  ga_qualify #(.SW(SW), .SUM_W(SUM_W), .NUM(Q_NUM), .DEN(Q_DEN)) u_qual (
    .score(fit[idx]), .total(sum), .pass(qual)
  );

  ga_breed #(.CW(CW), .CUT_W(CUT_W), .POS_W(POS_W)) u_breed (
    .pa(pa), .pb(pb), .do_x(dx), .cut(cut),
    .do_m0(dm0), .pos0(pos0), .do_m1(dm1), .pos1(pos1),
    .c0(c0), .c1(c1)
  );

  // Scale random bytes into ranges without division: (r * n) >> 8
  always_comb begin
    logic [15:0] pa_p, pb_p, cu_p, p0_p, p1_p;
    pa_p  = {8'd0, rnd[7:0]}  * 16'(nsel);
    pb_p  = {8'd0, rnd[15:8]} * 16'(nsel);
    cu_p  = {8'd0, rnd[15:8]} * 16'(CW - 1);
    p0_p  = {8'd0, rnd[7:0]}  * 16'(CW);
    p1_p  = {8'd0, rnd[15:8]} * 16'(CW);
    ia    = IDX_W'(pa_p[15:8]);
    ib    = IDX_W'(pb_p[15:8]);
    cut_n = CUT_W'(cu_p[15:8]) + CUT_W'(1);
    pos0  = POS_W'(p0_p[15:8]);
    pos1  = POS_W'(p1_p[15:8]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      idx        <= '0;
      nsel       <= '0;
      pair       <= '0;
      sum        <= '0;
      gen_cnt    <= '0;
      lim_q      <= '0;
      xth_q      <= '0;
      mth_q      <= '0;
      gb_chrom   <= '0;
      gb_score   <= '0;
      pa         <= '0;
      pb         <= '0;
      dx         <= 1'b0;
      dm0        <= 1'b0;
      dm1        <= 1'b0;
      cut        <= '0;
      eval_req   <= 1'b0;
      eval_chrom <= '0;
      done       <= 1'b0;
      best_chrom <= '0;
      best_score <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            lim_q      <= gen_limit;
            xth_q      <= xover_th;
            mth_q      <= mut_th;
            gen_cnt    <= '0;
            best_chrom <= '0;
            best_score <= '0;
            done       <= 1'b0;
            idx        <= '0;
            st         <= ST_SEED;
          end
        end
        ST_SEED: begin
          pop[idx] <= rnd[CW-1:0];
          idx      <= idx + 1'b1;
          if (idx == IDX_W'(POP_N - 1)) begin
            sum <= '0;
            st  <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          eval_req   <= 1'b1;
          eval_chrom <= pop[idx];
          st         <= ST_WAIT;
        end
        ST_WAIT: begin
          if (eval_valid) begin
            eval_req <= 1'b0;
            fit[idx] <= eval_score;
            sum      <= sum + SUM_W'(eval_score);
            if (eval_score > best_score) begin
              best_score <= eval_score;
              best_chrom <= eval_chrom;
            end
            if (idx == '0 || eval_score > gb_score) begin
              gb_score <= eval_score;
              gb_chrom <= eval_chrom;
            end
            if (eval_score == MAX_S) begin
              done <= 1'b1;
              st   <= ST_DONE;
            end else if (idx == IDX_W'(POP_N - 1)) begin
              gen_cnt <= gen_cnt + 1'b1;
              idx     <= '0;
              nsel    <= '0;
              if (gen_cnt + 1'b1 >= {1'b0, lim_q}) begin
                done <= 1'b1;
                st   <= ST_DONE;
              end else begin
                st <= ST_SELECT;
              end
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_ISSUE;
            end
          end
        end
        ST_SELECT: begin
          if (qual) begin
            pool[nsel[IDX_W-1:0]] <= pop[idx];
            nsel <= nsel + 1'b1;
          end
          idx <= idx + 1'b1;
          if (idx == IDX_W'(POP_N - 1)) st <= ST_FIX;
        end
        ST_FIX: begin
          if (nsel < (IDX_W+1)'(2)) begin
            pool[0] <= gb_chrom;
            pool[1] <= gb_chrom;
            nsel    <= (IDX_W+1)'(2);
          end
          pair <= '0;
          st   <= ST_PICK;
        end
        ST_PICK: begin
          pa <= pool[ia];
          pb <= pool[ib];
          st <= ST_CROSS;
        end
        ST_CROSS: begin
          dx  <= rnd[7:0] < xth_q;
          cut <= cut_n;
          st  <= ST_MUT;
        end
        ST_MUT: begin
          dm0 <= rnd[7:0] < mth_q;
          dm1 <= rnd[15:8] < mth_q;
          st  <= ST_WRITE;
        end
        ST_WRITE: begin
          pop[{pair, 1'b0}] <= c0;
          pop[{pair, 1'b1}] <= c1;
          if (pair == PAIR_W'(PAIRS - 1)) begin
            idx <= '0;
            sum <= '0;
            st  <= ST_ISSUE;
          end else begin
            pair <= pair + 1'b1;
            st   <= ST_PICK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ga_search_engine_chk.sv
module ga_search_engine_chk #(
  parameter int CW = 5,
  parameter int SW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          eval_req,
  input logic [CW-1:0] eval_chrom,
  input logic          eval_valid,
  input logic [SW-1:0] eval_score,
  input logic          done,
  input logic [SW-1:0] best_score
);
  assert_hold_req_R2: assert property (@(posedge clk) disable iff (rst)
    eval_req && !eval_valid |=> eval_req && $stable(eval_chrom));

  assert_drop_req_R2: assert property (@(posedge clk) disable iff (rst)
    eval_req && eval_valid |=> !eval_req);

  assert_idle_when_done_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> !eval_req);

  assert_best_grows_R4: assert property (@(posedge clk) disable iff (rst)
    !start |=> best_score >= $past(best_score));

  assert_stop_on_max_R8: assert property (@(posedge clk) disable iff (rst)
    eval_req && eval_valid && (eval_score == {SW{1'b1}}) |=> done);

  assert_done_holds_R10: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);
endmodule

bind ga_search_engine ga_search_engine_chk #(.CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .eval_req(eval_req),
  .eval_chrom(eval_chrom), .eval_valid(eval_valid), .eval_score(eval_score),
  .done(done), .best_score(best_score)
);

// File: tb/sim_ga_search_engine.sv
module sim_ga_search_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] gen_limit = 8'd1, xover_th = 8'd0, mut_th = 8'd0;
  logic       eval_req, eval_valid = 1'b0, done;
  logic [4:0] eval_chrom, best_chrom;
  logic [7:0] eval_score = 8'd0, best_score;

  int checks = 0, bad = 0, cycles = 0;
  logic [4:0] gc [8];
  logic [7:0] gs [8];
  logic [4:0] pool [8];
  int         npool;
  logic [4:0] m_best_c, last_c;
  logic [7:0] m_best_s;

  always #10 clk = ~clk;

  ga_search_engine u0 (
    .clk(clk), .rst(rst), .start(start), .gen_limit(gen_limit),
    .xover_th(xover_th), .mut_th(mut_th), .eval_req(eval_req),
    .eval_chrom(eval_chrom), .eval_valid(eval_valid), .eval_score(eval_score),
    .done(done), .best_chrom(best_chrom), .best_score(best_score)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  function automatic int hd(input logic [4:0] a, input logic [4:0] b);
    return $countones(a ^ b);
  endfunction

  function automatic logic [4:0] splice(input logic [4:0] a, input logic [4:0] b, input int k);
    logic [4:0] m;
    m = 5'h1f << k;
    return (a & ~m) | (b & m);
  endfunction

  // parent pool of the generation held in gc/gs (R5, R6)
  task automatic build_pool();
    int sum = 0, bi = 0;
    npool = 0;
    for (int i = 0; i < 8; i++) sum += gs[i];
    for (int i = 0; i < 8; i++) if (10 * gs[i] > 8 * sum) begin
      pool[npool] = gc[i];
      npool++;
    end
    if (npool < 2) begin
      for (int i = 1; i < 8; i++) if (gs[i] > gs[bi]) bi = i;
      pool[0] = gc[bi];
      pool[1] = gc[bi];
      npool = 2;
    end
  endtask

  function automatic bit reachable(input logic [4:0] c, input int xth, input int mth);
    int lim = (mth == 0) ? 0 : 1;
    for (int a = 0; a < npool; a++)
      for (int b = 0; b < npool; b++) begin
        if (hd(c, pool[a]) <= lim) return 1'b1;
        if (xth != 0)
          for (int k = 1; k < 5; k++)
            if (hd(c, splice(pool[a], pool[b], k)) <= lim ||
                hd(c, splice(pool[b], pool[a], k)) <= lim) return 1'b1;
      end
    return 1'b0;
  endfunction

  function automatic logic [7:0] pick_score(input int mode, input int g, input int gi, input int n);
    case (mode)
      1:       return (n == 4) ? 8'd255 : 8'($urandom % 255);
      2:       return 8'd7;
      3:       return 8'd0;
      4:       return (gi == (g % 8)) ? 8'd250 : 8'($urandom % 4);
      default: return 8'($urandom % 255);
    endcase
  endfunction

  task automatic run(input int lim, input int xth, input int mth, input int mode,
                     input bit mid_start, output int nev);
    @(negedge clk);
    gen_limit = 8'(lim); xover_th = 8'(xth); mut_th = 8'(mth);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    nev = 0; m_best_c = '0; m_best_s = '0;
    while (nev < 3000) begin
      @(negedge clk);
      if (done) break;
      if (eval_req) begin
        int g = nev / 8, gi = nev % 8, w = $urandom % 3;
        logic [4:0] c = eval_chrom;
        logic [7:0] s;
        if (gi == 0 && g > 0) build_pool();
        if (g > 0) begin
          if (xth == 0 && mth == 0)
            chk(reachable(c, 0, 0), "R6/R7 child in pool", c, pool[0]);
          else
            chk(reachable(c, xth, mth), "R7 child reachable", c, pool[0]);
        end
        for (int k = 0; k < w; k++) begin
          @(negedge clk);
          chk(eval_req && eval_chrom == c, "R2 request held", eval_chrom, c);
        end
        s = pick_score(mode, g, gi, nev);
        eval_valid = 1'b1; eval_score = s;
        @(negedge clk);
        eval_valid = 1'b0;
        chk(!eval_req, "R2/R3 request dropped", eval_req, 0);
        gc[gi] = c; gs[gi] = s; last_c = c;
        if (s > m_best_s) begin m_best_s = s; m_best_c = c; end
        nev++;
        if (mid_start && nev == 3) begin
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    end
    chk(best_score == m_best_s, "R4 best score", best_score, m_best_s);
    chk(best_chrom == m_best_c, "R4 best chrom", best_chrom, m_best_c);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!done && !eval_req, "R1 reset outputs", {done, eval_req}, 0);
    chk(best_score == 0 && best_chrom == 0, "R1 reset best", best_score, 0);
    @(negedge clk);
    rst = 1'b0;

    // R9/R10: three generations, mid-run start ignored, exact pool children
    run(3, 0, 0, 0, 1'b1, n);
    chk(n == 24, "R9 R10 eval count", n, 24);
    chk(done, "R9 done raised", done, 1);
    repeat (5) @(negedge clk);
    chk(done && !eval_req, "R10 done held", {done, eval_req}, 2);

    // R5: one dominant scorer per generation, no operators
    run(3, 0, 0, 4, 1'b0, n);
    chk(n == 24, "R5 eval count", n, 24);

    // R7: operators on with dominant scorer
    run(4, 255, 255, 4, 1'b0, n);
    chk(n == 32, "R7 eval count", n, 32);

    // R8: max score ends the search
    run(5, 128, 128, 1, 1'b0, n);
    chk(n == 5, "R8 stop count", n, 5);
    chk(best_score == 8'd255 && best_chrom == last_c, "R8 best is max", best_chrom, last_c);

    // R6/R4: all-zero scores keep best at 0/0
    run(2, 0, 0, 3, 1'b0, n);
    chk(n == 16, "R6 zero count", n, 16);
    chk(best_score == 0 && best_chrom == 0, "R4 zero best", best_chrom, 0);

    // R6: all-equal scores, earliest first wins
    run(3, 200, 0, 2, 1'b0, n);
    chk(n == 24, "R6 equal count", n, 24);

    // R9: limit 0 acts as 1
    run(0, 0, 0, 2, 1'b0, n);
    chk(n == 8, "R9 limit zero", n, 8);

    // constrained random mix
    for (int r = 0; r < 6; r++) begin
      int lim = 1 + $urandom % 4;
      int md  = (r % 2 == 0) ? 0 : 4;
      run(lim, $urandom % 256, $urandom % 256, md, 1'b0, n);
      chk(n == 8 * lim, "R9 random count", n, 8 * lim);
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule